// File: doc/BRIEF.md
# Slow-Control Bus Node Receiver and Responder

This block is the receiving and answering side of one node on a shared, half-duplex, multi-drop serial control bus. A bit-timing receiver turns the line into bytes. A frame parser collects these bytes into short command frames and checks a CRC-8 over each frame. It acts on a frame only when the frame is intact and this node has been selected. Writes leave the block as one-cycle strobes towards a register space. That space has two banks, channels and configuration parameters, and each bank holds 256 entries reached by an 8-bit index. Reads pull a value from that space in one cycle and send it back as a reply frame. The reply goes through a bit-timing transmitter that also drives the enable of the line driver.

Selection follows a simple rule. A host first sends an address frame that carries a 16-bit node number. Every node compares that number with its own `node_addr` pins. The node that matches stays selected until the next address frame arrives. Nodes that do not match drop out. A host can ask for a short acknowledge after a write by setting the top bit of the command byte. Reads always return a reply. A frame with a bad CRC, a byte with a broken stop bit, an unknown command code, or a frame left unfinished for too long all leave the outputs quiet.

Top module: `scbus_node`

## Requirements
- R1: The line is idle high. Characters are 8N1: a low start bit, eight data bits least-significant first, and a high stop bit, each bit lasting CLKS_PER_BIT clocks. A character whose stop bit samples low is discarded.
- R2: Each frame ends with a CRC-8 byte. The CRC uses polynomial 0x07 (x^8+x^2+x+1), starts at 0x00, is processed MSB first, and covers all earlier bytes of the frame. On a mismatch the frame is dropped: no strobe, no reply, and no change to the selection.
- R3: Address frame: command 0x01, then the address low byte, then the address high byte, then the CRC. If {high,low} equals `node_addr`, the node becomes selected. Otherwise it becomes unselected.
- R4: Write frame: command 0x02 (channel bank) or 0x03 (parameter bank), then the index, then the value, then the CRC. When the node is selected, `reg_wr` pulses for one cycle with `reg_sel` (0 = channel, 1 = parameter), `reg_idx` and `reg_wdata`. When the node is not selected, the frame has no effect.
- R5: If bit 7 of a write command is set, the node replies with the two bytes 0xA5 and CRC. If bit 7 is clear, there is no reply.
- R6: Read frame: command 0x04 (channel) or 0x05 (parameter), then the index, then the CRC. When the node is selected, `reg_rd` pulses for one cycle with `reg_sel` and `reg_idx`. `reg_rdata` is taken in that same cycle, and the node replies with 0xA5, the data, and the CRC.
- R7: Reply bytes leave back to back as 8N1 characters. `drv_en` rises together with the first start bit and stays high for n*10*CLKS_PER_BIT + CLKS_PER_BIT cycles, where n is the number of reply bytes. `txd` is high whenever no character is being sent.
- R8: If more than GAP_CHARS*10*CLKS_PER_BIT cycles pass without a byte while a frame is incomplete, the partial frame is discarded.
- R9: A first byte whose low seven bits are not in the range 1 to 5 is ignored, and the parser keeps waiting for a command.
- R10: Reset leaves `reg_wr` and `reg_rd` low, `drv_en` low, `txd` high, and the node unselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_addr | input | 16 | This node's bus address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| drv_en | output | 1 | Line driver enable |
| reg_wr | output | 1 | Write strobe |
| reg_rd | output | 1 | Read strobe |
| reg_sel | output | 1 | Bank select, 0 channel, 1 parameter |
| reg_idx | output | 8 | Entry index |
| reg_wdata | output | 8 | Write value |
| reg_rdata | input | 8 | Read value, valid in the cycle reg_rd is high |

## Verification
The assertions assume that the host does not start a new frame until the node's reply has ended. With that assumption, a reply request never arrives while the transmitter is busy. They also assume that `reg_rdata` settles in the same cycle `reg_rd` is high. The stimulus keeps within both assumptions: after every frame it waits longer than the longest reply, and it serves reads from a combinational model of the register banks. Broken characters, bad CRC bytes, unknown commands and stalled partial frames are sent only between complete frames, so each one can be seen to leave no trace.

// File: rtl/scbus_pkg.sv
package scbus_pkg;

  localparam logic [2:0] OP_ADDR  = 3'd1;
  localparam logic [2:0] OP_WCHAN = 3'd2;
  localparam logic [2:0] OP_WPAR  = 3'd3;
  localparam logic [2:0] OP_RCHAN = 3'd4;
  localparam logic [2:0] OP_RPAR  = 3'd5;
  localparam logic [7:0] REPLY_HDR = 8'hA5;

  typedef enum logic [1:0] {P_IDLE, P_B1, P_B2, P_CRC} pstate_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rstate_t;

  // one byte of CRC-8, poly 0x07, MSB first
  function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/scbus_uart_rx.sv
module scbus_uart_rx
  import scbus_pkg::*;
#(
  parameter int CLKS_PER_BIT = 362
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

  logic          meta_q, sync_q;
  rstate_t       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    sh_q, sh_n;
  logic          vld_q, vld_n;
  logic [7:0]    dat_q, dat_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q + 1'b1;
    bit_n = bit_q;
    sh_n  = sh_q;
    vld_n = 1'b0;
    dat_n = dat_q;
    case (st_q)
      R_IDLE: begin
        cnt_n = '0;
        if (!sync_q) st_n = R_START;
      end
      R_START: if (cnt_q == HALF) begin
        cnt_n = '0;
        bit_n = '0;
        st_n  = sync_q ? R_IDLE : R_DATA;
      end
      R_DATA: if (cnt_q == FULL) begin
        cnt_n = '0;
        sh_n  = {sync_q, sh_q[7:1]};
        if (bit_q == 3'd7) st_n = R_STOP;
        else               bit_n = bit_q + 1'b1;
      end
      default: if (cnt_q == FULL) begin
        cnt_n = '0;
        st_n  = R_IDLE;
        if (sync_q) begin
          vld_n = 1'b1;
          dat_n = sh_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      st_q   <= R_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      meta_q <= rxd_i;
      sync_q <= meta_q;
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      vld_q  <= vld_n;
      dat_q  <= dat_n;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R1

endmodule

// File: rtl/scbus_uart_tx.sv
module scbus_uart_tx
  import scbus_pkg::*;
#(
  parameter int CLKS_PER_BIT = 362,
  parameter int MAX_BYTES    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [1:0]                len_i,
  input  logic [MAX_BYTES-1:0][7:0] bytes_i,
  output logic                      txd_o,
  output logic                      busy_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);

  logic                      busy_q, busy_n;
  logic                      tail_q, tail_n;
  logic [9:0]                frm_q, frm_n;
  logic [3:0]                bit_q, bit_n;
  logic [CW-1:0]             cnt_q, cnt_n;
  logic [1:0]                idx_q, idx_n;
  logic [1:0]                len_q, len_n;
  logic [MAX_BYTES-1:0][7:0] buf_q, buf_n;

  always_comb begin
    busy_n = busy_q;
    tail_n = tail_q;
    frm_n  = frm_q;
    bit_n  = bit_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    len_n  = len_q;
    buf_n  = buf_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_n = 1'b1;
        tail_n = 1'b0;
        buf_n  = bytes_i;
        len_n  = len_i;
        idx_n  = 2'd1;
        frm_n  = {1'b1, bytes_i[0], 1'b0};
        bit_n  = '0;
        cnt_n  = '0;
      end
    end else if (cnt_q != FULL) begin
      cnt_n = cnt_q + 1'b1;
    end else begin
      cnt_n = '0;
      if (tail_q) begin
        busy_n = 1'b0;
        tail_n = 1'b0;
      end else if (bit_q == 4'd9) begin
        bit_n = '0;
        if (idx_q == len_q) begin
          tail_n = 1'b1;
          frm_n  = '1;
        end else begin
          frm_n = {1'b1, buf_q[idx_q], 1'b0};
          idx_n = idx_q + 1'b1;
        end
      end else begin
        frm_n = {1'b1, frm_q[9:1]};
        bit_n = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
      frm_q  <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      buf_q  <= '0;
    end else begin
      busy_q <= busy_n;
      tail_q <= tail_n;
      frm_q  <= frm_n;
      bit_q  <= bit_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      len_q  <= len_n;
      buf_q  <= buf_n;
    end
  end

  assign txd_o  = busy_q ? frm_q[0] : 1'b1;
  assign busy_o = busy_q;

  AST_TX_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R7
  AST_DRV_WITH_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_o); // R7
  AST_TAIL_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q |-> txd_o); // R7

endmodule

// File: rtl/scbus_frame_parser.sv
module scbus_frame_parser
  import scbus_pkg::*;
#(
  parameter int CLKS_PER_BIT = 362,
  parameter int GAP_CHARS    = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     node_addr,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_data_i,
  input  logic            tx_busy_i,
  output logic            tx_start_o,
  output logic [1:0]      tx_len_o,
  output logic [2:0][7:0] tx_bytes_o,
  output logic            reg_wr,
  output logic            reg_rd,
  output logic            reg_sel,
  output logic [7:0]      reg_idx,
  output logic [7:0]      reg_wdata,
  input  logic [7:0]      reg_rdata
);
  localparam int GAP_CLKS = GAP_CHARS * 10 * CLKS_PER_BIT;
  localparam int GW = $clog2(GAP_CLKS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CLKS - 1);

  pstate_t        st_q, st_n;
  logic [2:0]     op_q, op_n;
  logic           ack_q, ack_n;
  logic [7:0]     b1_q, b1_n, b2_q, b2_n, crc_q, crc_n;
  logic [GW-1:0]  gap_q, gap_n;
  logic           sel_q, sel_n;
  logic           wr_q, wr_n, rd_q, rd_n, bank_q, bank_n;
  logic [7:0]     idx_q, idx_n, wd_q, wd_n;
  logic           txs_q, txs_n;
  logic [1:0]     txl_q, txl_n;
  logic [2:0][7:0] txb_q, txb_n;

  logic byte_ok, op_ok, is_read;

  assign byte_ok = rx_valid_i && !tx_busy_i;
  assign op_ok   = (rx_data_i[6:3] == 4'd0) && (rx_data_i[2:0] >= OP_ADDR) &&
                   (rx_data_i[2:0] <= OP_RPAR);
  assign is_read = (op_q == OP_RCHAN) || (op_q == OP_RPAR);

  always_comb begin
    st_n  = st_q;
    op_n  = op_q;
    ack_n = ack_q;
    b1_n  = b1_q;
    b2_n  = b2_q;
    crc_n = crc_q;
    sel_n = sel_q;
    wr_n  = 1'b0;
    rd_n  = 1'b0;
    bank_n = bank_q;
    idx_n = idx_q;
    wd_n  = wd_q;
    txs_n = 1'b0;
    txl_n = txl_q;
    txb_n = txb_q;
    gap_n = (st_q == P_IDLE || byte_ok) ? '0 : gap_q + 1'b1;

    case (st_q)
      P_IDLE: if (byte_ok && op_ok) begin
        op_n  = rx_data_i[2:0];
        ack_n = rx_data_i[7];
        crc_n = crc8_next(8'h00, rx_data_i);
        st_n  = P_B1;
      end
      P_B1: if (byte_ok) begin
        b1_n  = rx_data_i;
        crc_n = crc8_next(crc_q, rx_data_i);
        st_n  = is_read ? P_CRC : P_B2;
      end
      P_B2: if (byte_ok) begin
        b2_n  = rx_data_i;
        crc_n = crc8_next(crc_q, rx_data_i);
        st_n  = P_CRC;
      end
      default: if (byte_ok) begin
        st_n = P_IDLE;
        if (rx_data_i == crc_q) begin
          if (op_q == OP_ADDR) begin
            sel_n = ({b2_q, b1_q} == node_addr);
          end else if (sel_q) begin
            bank_n = (op_q == OP_WPAR) || (op_q == OP_RPAR);
            idx_n  = b1_q;
            if (is_read) begin
              rd_n = 1'b1;
            end else begin
              wr_n = 1'b1;
              wd_n = b2_q;
              if (ack_q) begin
                txs_n    = 1'b1;
                txl_n    = 2'd2;
                txb_n[0] = REPLY_HDR;
                txb_n[1] = crc8_next(8'h00, REPLY_HDR);
                txb_n[2] = 8'h00;
              end
            end
          end
        end
      end
    endcase

    if (st_q != P_IDLE && !byte_ok && gap_q == GAP_LAST) begin
      st_n  = P_IDLE;
      gap_n = '0;
    end

    if (rd_q) begin
      txs_n    = 1'b1;
      txl_n    = 2'd3;
      txb_n[0] = REPLY_HDR;
      txb_n[1] = reg_rdata;
      txb_n[2] = crc8_next(crc8_next(8'h00, REPLY_HDR), reg_rdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      op_q   <= '0;
      ack_q  <= 1'b0;
      b1_q   <= '0;
      b2_q   <= '0;
      crc_q  <= '0;
      gap_q  <= '0;
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      bank_q <= 1'b0;
      idx_q  <= '0;
      wd_q   <= '0;
      txs_q  <= 1'b0;
      txl_q  <= '0;
      txb_q  <= '0;
    end else begin
      st_q   <= st_n;
      op_q   <= op_n;
      ack_q  <= ack_n;
      b1_q   <= b1_n;
      b2_q   <= b2_n;
      crc_q  <= crc_n;
      gap_q  <= gap_n;
      sel_q  <= sel_n;
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      bank_q <= bank_n;
      idx_q  <= idx_n;
      wd_q   <= wd_n;
      txs_q  <= txs_n;
      txl_q  <= txl_n;
      txb_q  <= txb_n;
    end
  end

  assign tx_start_o = txs_q;
  assign tx_len_o   = txl_q;
  assign tx_bytes_o = txb_q;
  assign reg_wr     = wr_q;
  assign reg_rd     = rd_q;
  assign reg_sel    = bank_q;
  assign reg_idx    = idx_q;
  assign reg_wdata  = wd_q;

  AST_WR_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> sel_q); // R4
  AST_RD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> sel_q); // R6
  AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_LAST); // R8
  AST_READ_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> txs_q); // R6

endmodule

// File: rtl/scbus_node.sv
module scbus_node
  import scbus_pkg::*;
#(
  parameter int CLKS_PER_BIT = 362,
  parameter int GAP_CHARS    = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] node_addr,
  input  logic        rxd,
  output logic        txd,
  output logic        drv_en,
  output logic        reg_wr,
  output logic        reg_rd,
  output logic        reg_sel,
  output logic [7:0]  reg_idx,
  output logic [7:0]  reg_wdata,
  input  logic [7:0]  reg_rdata
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            rx_vld;
  logic [7:0]      rx_dat;
  logic            tx_busy, tx_go;
  logic [1:0]      tx_len;
  logic [2:0][7:0] tx_bytes;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scbus_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_i (
    .clk(clk), .rst_n(rst_int_n), .rxd_i(rxd),
    .valid_o(rx_vld), .data_o(rx_dat));

  scbus_frame_parser #(.CLKS_PER_BIT(CLKS_PER_BIT), .GAP_CHARS(GAP_CHARS)) prs_i (
    .clk(clk), .rst_n(rst_int_n), .node_addr(node_addr),
    .rx_valid_i(rx_vld), .rx_data_i(rx_dat), .tx_busy_i(tx_busy),
    .tx_start_o(tx_go), .tx_len_o(tx_len), .tx_bytes_o(tx_bytes),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  scbus_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .MAX_BYTES(3)) tx_i (
    .clk(clk), .rst_n(rst_int_n), .start_i(tx_go), .len_i(tx_len),
    .bytes_i(tx_bytes), .txd_o(txd), .busy_o(tx_busy));

  assign drv_en = tx_busy;

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(reg_wr && reg_rd)); // R4
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    !drv_en |-> txd); // R7

endmodule

// File: tb/scbus_node_tb_top.sv
module scbus_node_tb_top;
  localparam int CPB  = 16;
  localparam int GAPC = 10;
  localparam int GAP_CLKS = GAPC * 10 * CPB;
  localparam logic [15:0] MY_ADDR = 16'h1234;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, drv_en, reg_wr, reg_rd, reg_sel;
  logic [7:0] reg_idx, reg_wdata, reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit model_sel = 1'b0;

  logic [17:0] exp_ev[$];   // {rd, bank, idx, data}
  logic [7:0]  exp_tx[$];
  int          exp_drv[$];

  always #4 clk = ~clk;

  scbus_node #(.CLKS_PER_BIT(CPB), .GAP_CHARS(GAPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .node_addr(MY_ADDR), .rxd(rxd), .txd(txd),
    .drv_en(drv_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [7:0] bank_val(input logic b, input logic [7:0] i);
    return b ? ~i : i + 8'h3C;
  endfunction
  assign reg_rdata = bank_val(reg_sel, reg_idx);

  // bit-serial CRC-8, poly 0x07
  function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good_stop);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = good_stop;
    repeat (CPB) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic settle();
    repeat (45 * CPB) @(negedge clk);
  endtask

  task automatic addr_frame(input logic [15:0] a, input bit good);
    logic [7:0] c;
    c = crc_add(crc_add(crc_add(8'h00, 8'h01), a[7:0]), a[15:8]);
    if (good) model_sel = (a == MY_ADDR);
    send_byte(8'h01, 1'b1);
    send_byte(a[7:0], 1'b1);
    send_byte(a[15:8], 1'b1);
    send_byte(good ? c : c ^ 8'h01, 1'b1);
    settle();
  endtask

  task automatic wr_frame(input bit par, input bit ack, input logic [7:0] idx,
                          input logic [7:0] val, input bit good);
    logic [7:0] cmd, c;
    cmd = {ack, 4'd0, par ? 3'd3 : 3'd2};
    c = crc_add(crc_add(crc_add(8'h00, cmd), idx), val);
    if (good && model_sel) begin
      exp_ev.push_back({1'b0, par, idx, val});
      if (ack) begin
        exp_tx.push_back(8'hA5);
        exp_tx.push_back(crc_add(8'h00, 8'hA5));
        exp_drv.push_back(2 * 10 * CPB + CPB);
      end
    end
    send_byte(cmd, 1'b1);
    send_byte(idx, 1'b1);
    send_byte(val, 1'b1);
    send_byte(good ? c : ~c, 1'b1);
    settle();
  endtask

  task automatic rd_frame(input bit par, input logic [7:0] idx, input bit good);
    logic [7:0] cmd, c, v;
    cmd = par ? 8'h05 : 8'h04;
    c = crc_add(crc_add(8'h00, cmd), idx);
    v = bank_val(par, idx);
    if (good && model_sel) begin
      exp_ev.push_back({1'b1, par, idx, 8'h00});
      exp_tx.push_back(8'hA5);
      exp_tx.push_back(v);
      exp_tx.push_back(crc_add(crc_add(8'h00, 8'hA5), v));
      exp_drv.push_back(3 * 10 * CPB + CPB);
    end
    send_byte(cmd, 1'b1);
    send_byte(idx, 1'b1);
    send_byte(good ? c : c ^ 8'h80, 1'b1);
    settle();
  endtask

  // strobe monitor, every clock
  always @(negedge clk) begin
    if (rst_n && (reg_wr || reg_rd)) begin
      if (exp_ev.size() == 0) begin
        check(1'b0, "R4/R6 unexpected strobe", {reg_rd, reg_sel, reg_idx, reg_wdata}, 0);
      end else begin
        logic [17:0] e;
        logic [17:0] a;
        e = exp_ev.pop_front();
        a = {reg_rd, reg_sel, reg_idx, (reg_rd ? 8'h00 : reg_wdata)};
        check(a == e && !(reg_wr && reg_rd), e[17] ? "R6 read strobe" : "R4 write strobe",
              a, e);
      end
    end
    if (rst_n && !drv_en && !txd) check(1'b0, "R7 line low while driver off", 0, 1);
  end

  // driver enable duration
  int drv_run = 0;
  always @(negedge clk) begin
    if (drv_en) drv_run++;
    else if (drv_run > 0) begin
      if (exp_drv.size() == 0) check(1'b0, "R7 unexpected reply", drv_run, 0);
      else begin
        int e;
        e = exp_drv.pop_front();
        check(drv_run == e, "R7 driver enable length", drv_run, e);
      end
      drv_run = 0;
    end
  end

  // reply byte decoder
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (CPB / 2 - 1) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = txd;
        end
        repeat (CPB) @(negedge clk);
        check(txd == 1'b1, "R7 reply stop bit", txd, 1);
        if (exp_tx.size() == 0) check(1'b0, "R5/R6 unexpected reply byte", b, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          check(b == e, "R5/R6 reply byte", b, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reg_wr == 0 && reg_rd == 0, "R10 strobes in reset", {reg_wr, reg_rd}, 0);
    check(drv_en == 0 && txd == 1, "R10 line in reset", {drv_en, txd}, 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(drv_en == 0 && txd == 1, "R10 line after reset", {drv_en, txd}, 1);

    // R10/R4: not selected after reset, writes ignored
    wr_frame(1'b0, 1'b1, 8'h10, 8'h55, 1'b1);
    // R3: select; swapped byte order must not match
    addr_frame(16'h3412, 1'b1);
    wr_frame(1'b0, 1'b0, 8'h11, 8'h66, 1'b1);
    addr_frame(MY_ADDR, 1'b1);
    // R4 plain writes, both banks
    wr_frame(1'b0, 1'b0, 8'h10, 8'h55, 1'b1);
    wr_frame(1'b1, 1'b0, 8'hFF, 8'h00, 1'b1);
    // R5 acknowledged write
    wr_frame(1'b1, 1'b1, 8'h07, 8'hC3, 1'b1);
    // R6 reads
    rd_frame(1'b0, 8'h22, 1'b1);
    rd_frame(1'b1, 8'h00, 1'b1);
    // R2 bad CRC on write and read
    wr_frame(1'b0, 1'b1, 8'h30, 8'h31, 1'b0);
    rd_frame(1'b0, 8'h40, 1'b0);
    // R2 bad address CRC keeps selection
    addr_frame(16'h9999, 1'b0);
    wr_frame(1'b0, 1'b0, 8'h41, 8'h42, 1'b1);
    // R1 broken stop bit on a would-be command byte
    send_byte(8'h02, 1'b0);
    repeat (2 * CPB) @(negedge clk);
    wr_frame(1'b1, 1'b0, 8'h50, 8'h51, 1'b1);
    // R9 unknown command followed at once by a valid frame
    send_byte(8'h07, 1'b1);
    wr_frame(1'b0, 1'b0, 8'h60, 8'h61, 1'b1);
    send_byte(8'h86, 1'b1);
    rd_frame(1'b1, 8'h61, 1'b1);
    // R8 stalled partial frame then fresh frame
    send_byte(8'h02, 1'b1);
    send_byte(8'h70, 1'b1);
    repeat (GAP_CLKS + 20 * CPB) @(negedge clk);
    wr_frame(1'b0, 1'b0, 8'h71, 8'h72, 1'b1);
    // R3 deselect by other address
    addr_frame(16'h1235, 1'b1);
    wr_frame(1'b0, 1'b1, 8'h80, 8'h81, 1'b1);
    rd_frame(1'b0, 8'h82, 1'b1);

    repeat (20 * CPB) @(negedge clk);
    check(exp_ev.size() == 0, "R4/R6 missing strobes", exp_ev.size(), 0);
    check(exp_tx.size() == 0, "R5/R6 missing reply bytes", exp_tx.size(), 0);
    check(exp_drv.size() == 0, "R7 missing replies", exp_drv.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule